// File: doc/BRIEF.md
# Core-Coupled Interrupt File Arbiter

This block picks the winning interrupt identity inside the interrupt files of a hart that has its own external interrupt controller. Each identity has a pending bit, an enable bit per file, a software-set 8-bit priority and a delegate flag. The machine file arbitrates every pending, enabled identity that is not delegated. The optional supervisor file arbitrates only delegated identities. Each file applies its own threshold. It shows the winner as a top-interrupt word, and it raises a registered external-interrupt request toward the hart when its delivery enable is set.

Software claims the current winner by writing the file's top-interrupt register. The write strobe produces a one-hot claim pulse at the winning identity. The pending logic outside this block uses that pulse to clear the pending bit in the way the source mode requires. Source sampling, CSR address decode and trap entry are handled elsewhere.

Top module: `irq_file_arbiter`

## Requirements
- R1: After reset, both request outputs read 0. With no pending identity, both top-interrupt words read 0.
- R2: Among qualifying identities, the lowest priority value wins. When two values are equal, the lower identity number wins.
- R3: A threshold of 0 filters nothing. A nonzero threshold admits only identities whose priority is strictly less than it.
- R4: The top-interrupt word carries the winner's identity in bits 26:16 and its priority in bits 7:0, with every other bit 0. The word is all zeros when no identity qualifies. It follows its inputs in the same cycle.
- R5: A file's request output is registered. One clock edge after the top word is nonzero and delivery is enabled, the output reads 1. One edge after delivery is disabled, it reads 0.
- R6: While the top-write strobe is high, the claim output is one-hot at the current winner's identity bit. It is all zeros when the strobe is low or when no identity qualifies.
- R7: An identity with its delegate flag set never wins in the machine file. Only the supervisor file arbitrates it, and the supervisor file ignores identities that are not delegated.
- R8: Identity 0 is never selected, whatever its pending, enable or priority value.
- R9: Identities above the implemented count (parameter IMPL_IDS) are treated as never pending and never enabled.
- R10: The supervisor file uses its own enable bits, threshold and delivery enable, independently of the machine file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pending | input | N_ENTRIES | Pending bit per identity (bit 0 unused) |
| delegate | input | N_ENTRIES | Delegate-to-supervisor flag per identity |
| src_prio | input | N_ENTRIES*8 | Priority per identity, byte i belongs to identity i |
| m_enable | input | N_ENTRIES | Machine file enable bits |
| m_thresh | input | 8 | Machine file threshold |
| m_deliver | input | 1 | Machine file delivery enable |
| m_topei_wr | input | 1 | Machine top-interrupt write strobe (claim) |
| s_enable | input | N_ENTRIES | Supervisor file enable bits |
| s_thresh | input | 8 | Supervisor file threshold |
| s_deliver | input | 1 | Supervisor file delivery enable |
| s_topei_wr | input | 1 | Supervisor top-interrupt write strobe (claim) |
| m_eip | output | 1 | Registered machine external-interrupt request |
| m_topei | output | 32 | Machine top-interrupt word |
| m_claim | output | N_ENTRIES | Machine claim pulse, one-hot |
| s_eip | output | 1 | Registered supervisor external-interrupt request |
| s_topei | output | 32 | Supervisor top-interrupt word |
| s_claim | output | N_ENTRIES | Supervisor claim pulse, one-hot |

## Verification
The assertions assume the delegate flags, thresholds and delivery enables are synchronous inputs that settle before the clock edge. The request check compares the top word in one cycle with the request in the next. The stimulus changes inputs only on falling edges and holds each pattern for at least one full cycle. The write strobe is raised for one cycle at a time, so the one-hot claim check always sees a stable winner.

// File: rtl/irqf_pkg.sv
// Shared widths, the winner record and the top-word packing for the
// interrupt file arbiter. Assumes identities fit in 11 bits.
package irqf_pkg;
    localparam int PRIO_W     = 8;
    localparam int ID_W       = 11;
    localparam int TOP_ID_LSB = 16;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } irqf_pick_t;

    // Pack a winner into the 32-bit top-interrupt word; zero when empty.
    function automatic logic [31:0] irqf_pack_top(irqf_pick_t p);
        logic [31:0] w;
        w = '0;
        if (p.valid) begin
            w[TOP_ID_LSB +: ID_W] = p.id;
            w[PRIO_W-1:0]         = p.prio;
        end
        return w;
    endfunction
endpackage

// File: rtl/irqf_pick.sv
// Picks the lowest priority value among eligible identities; ties go to
// the lower identity because the scan replaces only on strictly lower.
// Assumes entry 0 is never eligible (the scan starts at 1).
module irqf_pick
    import irqf_pkg::*;
#(
    parameter int N_ENTRIES = 64
) (
    input  logic [N_ENTRIES-1:0]        elig,
    input  logic [N_ENTRIES*PRIO_W-1:0] prio_flat,
    output irqf_pick_t                  best
);
    // Linear scan for the minimum priority.
    always_comb begin
        best = '0;
        for (int i = 1; i < N_ENTRIES; i++) begin
            if (elig[i] && (!best.valid || prio_flat[i*PRIO_W +: PRIO_W] < best.prio)) begin
                best.valid = 1'b1;
                best.id    = ID_W'(i);
                best.prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqf_file.sv
// One interrupt file: qualifies candidates by enable, implemented range
// and threshold, selects the winner, forms the top word, the claim pulse
// and the registered request. Candidates arrive already split by delegation.
module irqf_file
    import irqf_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int IMPL_IDS  = 63
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_ENTRIES-1:0]        cand,
    input  logic [N_ENTRIES-1:0]        enable,
    input  logic [N_ENTRIES*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]           thresh,
    input  logic                        deliver,
    input  logic                        top_wr,
    output logic                        eip,
    output logic [31:0]                 topei,
    output logic [N_ENTRIES-1:0]        claim
);
    logic [N_ENTRIES-1:0] elig;
    irqf_pick_t           best;

    // Per-identity qualification: implemented, nonzero id, threshold pass.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_qual
        localparam bit IMPL = (g >= 1) && (g <= IMPL_IDS);
        if (IMPL) begin : g_on
            assign elig[g] = cand[g] && enable[g] &&
                             ((thresh == '0) || (prio_flat[g*PRIO_W +: PRIO_W] < thresh));
        end else begin : g_off
            assign elig[g] = 1'b0;
        end
    end

    irqf_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .elig      (elig),
        .prio_flat (prio_flat),
        .best      (best)
    );

    assign topei = irqf_pack_top(best);

    // One-hot claim at the winner while the top word is written.
    always_comb begin
        claim = '0;
        if (top_wr && best.valid) claim[best.id] = 1'b1;
    end

    // Registered external-interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) eip <= 1'b0;
        else        eip <= deliver && best.valid;
    end
endmodule

// File: rtl/irq_file_arbiter.sv
// Top: splits pending identities between the machine file and the
// optional supervisor file by delegate flag, and instantiates each file.
// Assumes src_pending is already the per-mode pending state.
module irq_file_arbiter
    import irqf_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int IMPL_IDS  = 63,
    parameter bit HAS_SUPER = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_ENTRIES-1:0]        src_pending,
    input  logic [N_ENTRIES-1:0]        delegate,
    input  logic [N_ENTRIES*PRIO_W-1:0] src_prio,
    input  logic [N_ENTRIES-1:0]        m_enable,
    input  logic [PRIO_W-1:0]           m_thresh,
    input  logic                        m_deliver,
    input  logic                        m_topei_wr,
    input  logic [N_ENTRIES-1:0]        s_enable,
    input  logic [PRIO_W-1:0]           s_thresh,
    input  logic                        s_deliver,
    input  logic                        s_topei_wr,
    output logic                        m_eip,
    output logic [31:0]                 m_topei,
    output logic [N_ENTRIES-1:0]        m_claim,
    output logic                        s_eip,
    output logic [31:0]                 s_topei,
    output logic [N_ENTRIES-1:0]        s_claim
);
    // Delegated identities go only to the supervisor file.
    logic [N_ENTRIES-1:0] m_cand;
    logic [N_ENTRIES-1:0] s_cand;
    assign m_cand = src_pending & ~delegate;
    assign s_cand = src_pending & delegate;

    irqf_file #(.N_ENTRIES(N_ENTRIES), .IMPL_IDS(IMPL_IDS)) u_mfile (
        .clk (clk), .rst_n (rst_n), .cand (m_cand), .enable (m_enable),
        .prio_flat (src_prio), .thresh (m_thresh), .deliver (m_deliver),
        .top_wr (m_topei_wr), .eip (m_eip), .topei (m_topei), .claim (m_claim)
    );

    if (HAS_SUPER) begin : g_sfile
        irqf_file #(.N_ENTRIES(N_ENTRIES), .IMPL_IDS(IMPL_IDS)) u_sfile (
            .clk (clk), .rst_n (rst_n), .cand (s_cand), .enable (s_enable),
            .prio_flat (src_prio), .thresh (s_thresh), .deliver (s_deliver),
            .top_wr (s_topei_wr), .eip (s_eip), .topei (s_topei), .claim (s_claim)
        );
    end else begin : g_nosfile
        logic unused_s;
        assign unused_s = ^{s_cand, s_enable, s_thresh, s_deliver, s_topei_wr};
        assign s_eip    = 1'b0;
        assign s_topei  = '0;
        assign s_claim  = '0;
    end
endmodule

// File: rtl/irq_file_arbiter_chk.sv
// Checker bound to the arbiter top: relates the top words, requests,
// claims and delegation flags over time.
module irq_file_arbiter_chk #(
    parameter int N_ENTRIES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_ENTRIES-1:0] delegate,
    input logic [7:0]           m_thresh,
    input logic [7:0]           s_thresh,
    input logic                 m_deliver,
    input logic                 s_deliver,
    input logic                 m_topei_wr,
    input logic                 s_topei_wr,
    input logic                 m_eip,
    input logic                 s_eip,
    input logic [31:0]          m_topei,
    input logic [31:0]          s_topei,
    input logic [N_ENTRIES-1:0] m_claim,
    input logic [N_ENTRIES-1:0] s_claim
);
    localparam int IDX_W = $clog2(N_ENTRIES);

    a_r5_m_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (m_deliver && m_topei != 32'd0) |=> m_eip);
    a_r5_m_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_deliver) |=> !m_eip);
    a_r5_s_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_deliver) |=> !s_eip);
    a_r6_m_claim_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_claim));
    a_r6_m_no_claim_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_topei_wr) |-> (m_claim == '0));
    a_r6_s_no_claim_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_topei_wr) |-> (s_claim == '0));
    a_r8_m_id_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (m_topei != 32'd0) |-> (m_topei[26:16] != 11'd0));
    a_r3_m_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (m_thresh != 8'd0 && m_topei != 32'd0) |-> (m_topei[7:0] < m_thresh));
    a_r10_s_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (s_thresh != 8'd0 && s_topei != 32'd0) |-> (s_topei[7:0] < s_thresh));
    a_r7_m_not_delegated: assert property (@(posedge clk) disable iff (!rst_n)
        (m_topei != 32'd0) |-> !delegate[m_topei[16 +: IDX_W]]);
    a_r7_s_delegated_only: assert property (@(posedge clk) disable iff (!rst_n)
        (s_topei != 32'd0) |-> delegate[s_topei[16 +: IDX_W]]);
    a_r4_m_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (m_topei[31:27] == 5'd0) && (m_topei[15:8] == 8'd0));
endmodule

bind irq_file_arbiter irq_file_arbiter_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk (clk), .rst_n (rst_n), .delegate (delegate),
    .m_thresh (m_thresh), .s_thresh (s_thresh),
    .m_deliver (m_deliver), .s_deliver (s_deliver),
    .m_topei_wr (m_topei_wr), .s_topei_wr (s_topei_wr),
    .m_eip (m_eip), .s_eip (s_eip), .m_topei (m_topei), .s_topei (s_topei),
    .m_claim (m_claim), .s_claim (s_claim)
);

// File: tb/tb_irq_file_arbiter.sv
module tb_irq_file_arbiter;
    localparam int CLK_P = 10;
    localparam int N     = 64;
    localparam int IMPL  = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pend = '0, deleg = '0, m_en = '1, s_en = '1;
    logic [7:0]     pr [N];
    logic [N*8-1:0] prio_flat;
    logic [7:0]     m_thr = '0, s_thr = '0;
    logic           m_dlv = 1'b0, s_dlv = 1'b0, m_wr = 1'b0, s_wr = 1'b0;
    logic           m_eip, s_eip;
    logic [31:0]    m_topei, s_topei;
    logic [N-1:0]   m_claim, s_claim;
    int             n_chk = 0, n_err = 0;
    bit             done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = pr[i];

    irq_file_arbiter #(.N_ENTRIES(N), .IMPL_IDS(IMPL), .HAS_SUPER(1'b1)) dut (
        .clk (clk), .rst_n (rst_n), .src_pending (pend), .delegate (deleg),
        .src_prio (prio_flat), .m_enable (m_en), .m_thresh (m_thr),
        .m_deliver (m_dlv), .m_topei_wr (m_wr), .s_enable (s_en),
        .s_thresh (s_thr), .s_deliver (s_dlv), .s_topei_wr (s_wr),
        .m_eip (m_eip), .m_topei (m_topei), .m_claim (m_claim),
        .s_eip (s_eip), .s_topei (s_topei), .s_claim (s_claim)
    );

    function automatic logic [31:0] top(int id, int p);
        return (32'(id) << 16) | 32'(p);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(); #1; endtask
    task automatic cyc(); @(negedge clk); #1; endtask

    task automatic t_reset();
        chk("R1 m_eip", 64'(m_eip), 0);
        chk("R1 s_eip", 64'(s_eip), 0);
        chk("R1 m_topei empty", 64'(m_topei), 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        pr[5] = 30; pr[9] = 10; pr[12] = 10;
        pend = '0; pend[5] = 1; pend[9] = 1; pend[12] = 1;
        settle();
        chk("R2 tie lower id", 64'(m_topei), 64'(top(9, 10)));
        chk("R4 format", 64'(m_topei), 64'h0009_000a);
    endtask

    task automatic t_threshold();
        @(negedge clk); m_thr = 10; settle();
        chk("R3 equal excluded", 64'(m_topei), 0);
        @(negedge clk); m_thr = 11; settle();
        chk("R3 strictly below", 64'(m_topei), 64'(top(9, 10)));
        @(negedge clk); m_thr = 0; settle();
        chk("R3 zero no filter", 64'(m_topei), 64'(top(9, 10)));
    endtask

    task automatic t_eip();
        cyc();
        chk("R5 no delivery", 64'(m_eip), 0);
        @(negedge clk); m_dlv = 1; settle();
        chk("R5 registered", 64'(m_eip), 0);
        cyc();
        chk("R5 raised", 64'(m_eip), 1);
    endtask

    task automatic t_claim();
        @(negedge clk); m_wr = 1; settle();
        chk("R6 claim onehot", 64'(m_claim), 64'h1 << 9);
        chk("R6 s no claim", 64'(s_claim), 0);
        @(negedge clk); m_wr = 0; pend[9] = 0; settle();
        chk("R6 claim ends", 64'(m_claim), 0);
        chk("R2 next winner", 64'(m_topei), 64'(top(12, 10)));
        @(negedge clk); pend = '0; m_wr = 1; settle();
        chk("R6 empty claim", 64'(m_claim), 0);
        chk("R4 empty word", 64'(m_topei), 0);
        @(negedge clk); m_wr = 0; pend[5] = 1; pend[9] = 1; pend[12] = 1;
    endtask

    task automatic t_deleg();
        @(negedge clk); deleg[9] = 1; settle();
        chk("R7 m skips delegated", 64'(m_topei), 64'(top(12, 10)));
        chk("R7 s takes delegated", 64'(s_topei), 64'(top(9, 10)));
        @(negedge clk); s_thr = 5; settle();
        chk("R10 s threshold", 64'(s_topei), 0);
        chk("R10 m unaffected", 64'(m_topei), 64'(top(12, 10)));
        @(negedge clk); s_thr = 0; s_dlv = 1; m_dlv = 0;
        cyc();
        chk("R10 s_eip", 64'(s_eip), 1);
        chk("R5 m_eip gated", 64'(m_eip), 0);
        @(negedge clk); s_en[9] = 0; settle();
        chk("R10 s enable", 64'(s_topei), 0);
        chk("R7 no fallback", 64'(m_topei), 64'(top(12, 10)));
        @(negedge clk); s_en[9] = 1; deleg = '0; s_dlv = 0;
    endtask

    task automatic t_id0();
        @(negedge clk); pend = '0; pend[0] = 1; pr[0] = 0; settle();
        chk("R8 id0 ignored", 64'(m_topei), 0);
        @(negedge clk); pend[3] = 1; pr[3] = 200; settle();
        chk("R8 id3 over id0", 64'(m_topei), 64'(top(3, 200)));
    endtask

    task automatic t_impl();
        @(negedge clk); pend[50] = 1; pr[50] = 0; settle();
        chk("R9 above impl", 64'(m_topei), 64'(top(3, 200)));
        @(negedge clk); pend[40] = 1; pr[40] = 1; settle();
        chk("R9 last impl", 64'(m_topei), 64'(top(40, 1)));
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) pr[i] = 8'hff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_priority();
        t_threshold();
        t_eip();
        t_claim();
        t_deleg();
        t_id0();
        t_impl();
        finish_up();
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end
endmodule